// File: doc/BRIEF.md
# Eight-Pin GPIO Register Bank with Read Polarity Inversion

This block holds the register state behind eight bidirectional port pins. A serial front end sends it a write or read strobe with a 2-bit register pointer and an 8-bit data byte. The bank stores the output levels, the pin directions and a per-bit read inversion mask. It drives an output-enable and an output-value vector toward the pads, and it samples the pad input vector through a synchronizer.

Each pin's direction comes from its configuration bit. A 1 leaves the pin undriven so that it acts as an input, and a 0 turns its driver on. The input register always follows the synchronized pad level, whichever way the pin is set. When software reads the input register, each bit can be flipped by the inversion mask. Reading the output register returns the stored flops, not what the pad shows.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output register is 0xFF, the inversion mask is 0x00 and the configuration register is 0xFF. `pin_oe` is 0x00, `pin_out` is 0xFF and `rd_data` is 0x00.
- R2: The pointer encoding is 0 = input, 1 = output, 2 = inversion mask, 3 = configuration. A write with `wr_en` high stores `wr_data` at the clock edge. A read with `rd_en` high loads the selected value into `rd_data` at the clock edge. `rd_data` holds its value in cycles without `rd_en`.
- R3: `pin_oe[i]` is the inverse of configuration bit i, so a bit of 1 turns the driver off and the pin is an input.
- R4: `pin_out[i]` equals output register bit i. While configuration bit i is 1 the bit reaches no pad, because `pin_oe[i]` is 0.
- R5: The input register takes `pin_in` through two flops. A pad change made before clock edge k first shows in a read whose `rd_en` is sampled at edge k+2. This holds whether or not the pin is configured as an output.
- R6: A read of the input register returns each synchronized pin bit XOR the matching mask bit, so a mask bit of 1 inverts that bit. The mask has no effect on reads of any other register or on `pin_out`.
- R7: A read of the output register returns the stored flop value, not the pad level.
- R8: A write to pointer 0 changes no register, `pin_out` or `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register pointer (0 input, 1 output, 2 mask, 3 config) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables, active high |

## Verification
Output and configuration flops drive the pads directly. A corrupt value there shows on `pin_out` or `pin_oe` on the clock edge that stored it. A corrupt inversion mask stays hidden until the input register is read, and then the bad bits come out flipped in `rd_data` one edge after the read strobe. A synchronizer that is one stage too short or too long shows up as a read that returns the new pad level one sample too early or too late. The bench therefore probes the read at both neighbouring edges.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OUT_RESET = '1,
  parameter logic [WIDTH-1:0] CFG_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  localparam logic [1:0] SEL_IN  = 2'd0;
  localparam logic [1:0] SEL_OUT = 2'd1;
  localparam logic [1:0] SEL_INV = 2'd2;
  localparam logic [1:0] SEL_CFG = 2'd3;
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic [WIDTH-1:0] out_q, inv_q, cfg_q;
  logic [WIDTH-1:0] in_view, rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RESET;
      inv_q <= '0;
      cfg_q <= CFG_RESET;
    end else if (wr_en) begin
      case (reg_sel)
        SEL_OUT: out_q <= wr_data;
        SEL_INV: inv_q <= wr_data;
        SEL_CFG: cfg_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign in_view = sync_q[LAST] ^ inv_q;

  always_comb begin
    case (reg_sel)
      SEL_IN:  rd_mux = in_view;
      SEL_OUT: rd_mux = out_q;
      SEL_INV: rd_mux = inv_q;
      default: rd_mux = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign pin_oe  = ~cfg_q;
  assign pin_out = out_q;

  p_cfg_write_drives_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_CFG) |=> (pin_oe == ~$past(wr_data)));

  p_out_write_drives_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_OUT) |=> (pin_out == $past(wr_data)));

  p_pads_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_input_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_IN) |=> ($stable(pin_out) && $stable(pin_oe)));

  p_out_read_is_flop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_sel == SEL_OUT) |=> (rd_data == pin_out));

  p_cfg_read_matches_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_sel == SEL_CFG) |=> (rd_data == ~pin_oe));

endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = 8'h00, pin_in = 8'h00;
  logic [7:0] rd_data, pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sel, output logic [7:0] d);
    rd_en = 1'b1; reg_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rd_data at reset", rd_data, 8'h00);
    check("R1 pin_oe at reset", pin_oe, 8'h00);
    check("R1 pin_out at reset", pin_out, 8'hFF);
    do_read(2'd1, v); check("R1 output reg default", v, 8'hFF);
    do_read(2'd2, v); check("R1 mask default", v, 8'h00);
    do_read(2'd3, v); check("R1 config default", v, 8'hFF);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    do_write(2'd1, 8'h5A);
    check("R4 pin_out after write", pin_out, 8'h5A);
    do_write(2'd3, 8'h0F);
    check("R3 pin_oe from config", pin_oe, 8'hF0);
    do_read(2'd3, v); check("R2 config readback", v, 8'h0F);
    do_write(2'd2, 8'h81);
    do_read(2'd2, v); check("R2 mask readback", v, 8'h81);
    @(negedge clk); @(negedge clk);
    check("R2 rd_data held without read", rd_data, 8'h81);
    check("R6 mask leaves pin_out alone", pin_out, 8'h5A);
    do_write(2'd2, 8'h00);
  endtask

  task automatic t_direction;
    do_write(2'd3, 8'hFF);
    check("R4 all inputs: no enables", pin_oe, 8'h00);
    check("R4 output bits kept while input", pin_out, 8'h5A);
    do_write(2'd3, 8'h00);
    check("R3 all outputs: all enables", pin_oe, 8'hFF);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    pin_in = 8'h33;
    repeat (4) @(negedge clk);
    pin_in = 8'hC6;
    do_read(2'd0, v); check("R5 read at edge k still old", v, 8'h33);
    do_read(2'd0, v); check("R5 read at edge k+1 still old", v, 8'h33);
    do_read(2'd0, v); check("R5 read at edge k+2 new, pins are outputs", v, 8'hC6);
  endtask

  task automatic t_polarity;
    logic [7:0] v;
    do_write(2'd2, 8'hF0);
    do_read(2'd0, v); check("R6 inverted input read", v, 8'hC6 ^ 8'hF0);
    do_read(2'd1, v); check("R6 mask not applied to output read", v, 8'h5A);
    do_write(2'd2, 8'h00);
    do_read(2'd0, v); check("R6 mask cleared passes input", v, 8'hC6);
  endtask

  task automatic t_out_readback;
    logic [7:0] v;
    do_write(2'd3, 8'hFF);
    do_write(2'd1, 8'h12);
    pin_in = 8'hED;
    repeat (3) @(negedge clk);
    do_read(2'd1, v); check("R7 output read returns flops", v, 8'h12);
    do_read(2'd0, v); check("R5 input read while inputs", v, 8'hED);
  endtask

  task automatic t_input_write;
    logic [7:0] v;
    do_write(2'd0, 8'h00);
    check("R8 pin_out unchanged", pin_out, 8'h12);
    check("R8 pin_oe unchanged", pin_oe, 8'h00);
    do_read(2'd0, v); check("R8 input reg unchanged", v, 8'hED);
    do_read(2'd2, v); check("R8 mask unchanged", v, 8'h00);
    do_read(2'd3, v); check("R8 config unchanged", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_direction();
    t_sync();
    t_polarity();
    t_out_readback();
    t_input_write();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule